// File: doc/BRIEF.md
# DMA Transfer Length Counter

This block holds the byte count for a SCSI controller's DMA transfers and tracks how much of a transfer is left. Software loads a 16-bit length, one byte at a time, into a staging copy. That copy only becomes the live count when a command arrives with its DMA bit set. When a transfer-information command starts, the block works out the length of the transfer. A count of zero stands for 65536 bytes. The length is then capped at 32 bytes in command phase, or at the magnitude of the pending phase length in any other phase.

The memory side reports moved bytes through a valid/ready beat stream. On each accepted beat, the block lowers the remaining length and returns the pending phase length adjusted for the direction of the transfer. When the remaining length reaches zero, the block does four things: it sets terminal count, posts the bus-service interrupt code, zeroes the live count and raises the interrupt line.

Top module: `xfer_len_counter`

## Requirements
- R1: After reset, the live count, remaining length, busy, terminal count (`tc`), interrupt, interrupt code and `done` are all zero.
- R2: A host write puts byte lane `cnt_wr_sel` (0 = bits 7:0, 1 = bits 15:8) into the staging count. `cnt_live` copies the staging count only on a command whose `cmd_code` bit 7 is set; a command with bit 7 clear leaves `cnt_live` unchanged.
- R3: A host count write clears `tc` at the next edge.
- R4: A transfer-information start is `cmd_code` 0x90 (bit 7 set, bits 6:0 = 0x10) and uses the staging count. A staging count of 0 counts as 65536.
- R5: The start length is min(count, 32) when `cmd_phase` is high. Otherwise it is min(count, |`pend_len`|), with `pend_len` read as two's complement. It appears on `rem_len` the cycle after the start.
- R6: A start clears `tc`. It sets `busy` when the length is non-zero, and it replaces any remaining length from a transfer already under way.
- R7: A beat is accepted only when `mv_valid` and `mv_ready` are both high. `mv_ready` is high only while `busy` is high and no start is presented in the same cycle. Each accepted beat lowers `rem_len` by min(`mv_bytes`, `rem_len`), so `rem_len` never wraps below zero.
- R8: In a cycle with an accepted beat of m bytes, `pend_out` equals `pend_len` + m when `pend_len` is negative (toward the device) and `pend_len` − m otherwise. With no accepted beat, `pend_out` equals `pend_len`.
- R9: In the cycle right after the beat that brings `rem_len` to zero, the following all hold: `done` is high for that cycle, `tc` and `irq` are 1, `intr_code` is 0x10, `cnt_live` is 0, `rem_len` is 0 and `busy` is 0.
- R10: When completion and a host count write, or completion and `irq_ack`, fall in the same cycle, completion wins: `tc` and `irq` are 1 afterwards.
- R11: `irq_ack` clears `irq`, `intr_code` and `tc` at the next edge.
- R12: A start whose computed length is zero completes at once, with `done` and the flags of R9 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_wr_en | input | 1 | Host write strobe for a count byte |
| cnt_wr_sel | input | 1 | Byte lane select, 0 low, 1 mid |
| cnt_wr_data | input | 8 | Count byte value |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code, bit 7 = DMA |
| pend_len | input | 18 | Pending phase length, two's complement, negative toward device |
| cmd_phase | input | 1 | Bus is in command phase |
| mv_valid | input | 1 | Moved-bytes beat valid |
| mv_bytes | input | 8 | Bytes moved in this beat |
| mv_ready | output | 1 | Beat accepted when high with mv_valid |
| irq_ack | input | 1 | Interrupt acknowledge |
| pend_out | output | 18 | Pending length after this cycle's beat |
| cnt_live | output | 16 | Readable live count |
| rem_len | output | 17 | Remaining transfer length |
| busy | output | 1 | Transfer in progress |
| tc | output | 1 | Terminal count flag |
| irq | output | 1 | Interrupt line |
| intr_code | output | 8 | Interrupt code |
| done | output | 1 | One-cycle completion pulse |

## Verification
Completion can land in the same cycle as a clear from the host side, either a count-byte write or an interrupt acknowledge. The bench sets up a transfer with a small remaining length. It then presents the final beat together with `cnt_wr_en` and `irq_ack` in that one cycle, and expects `tc`, `irq` and `intr_code` to show completion afterwards rather than the clear. Random transfers with random beat sizes and stalls then compare `rem_len` and `pend_out` on every beat against a model written from the length rules.

// File: rtl/xfer_cnt_pkg.sv
package xfer_cnt_pkg;
  localparam logic [6:0] OP_XFER_INFO     = 7'h10;
  localparam logic [7:0] INTR_BUS_SERVICE = 8'h10;
endpackage

// File: rtl/xfer_cnt_regs.sv
// Staging and live copies of the transfer count, one byte lane per generate slice.
module xfer_cnt_regs #(
  parameter int CNT_W  = 16,
  parameter int NBYTES = CNT_W / 8,
  parameter int SEL_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [7:0]       wr_data,
  input  logic             reload,
  input  logic             clear,
  output logic [CNT_W-1:0] stage,
  output logic [CNT_W-1:0] live
);
  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stage[b*8 +: 8] <= '0;
      end else if (wr_en && (wr_sel == SEL_W'(b))) begin
        stage[b*8 +: 8] <= wr_data;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
        live[b*8 +: 8] <= '0;
      end else if (reload) begin
        live[b*8 +: 8] <= stage[b*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/xfer_len_calc.sv
// Start length: zero count means full range, then clamp to phase limit.
module xfer_len_calc #(
  parameter int CNT_W     = 16,
  parameter int PEND_W    = 18,
  parameter int CMD_LIMIT = 32,
  localparam int REM_W    = CNT_W + 1
) (
  input  logic [CNT_W-1:0]  count,
  input  logic              cmd_phase,
  input  logic [PEND_W-1:0] pend,
  output logic [REM_W-1:0]  len
);
  localparam int EW = PEND_W + 1;

  logic [EW-1:0] eff, pend_x, mag, lim;

  always_comb begin
    eff    = (count == '0) ? (EW'(1) << CNT_W) : EW'(count);
    pend_x = {pend[PEND_W-1], pend};
    mag    = pend_x[EW-1] ? (~pend_x + EW'(1)) : pend_x;
    lim    = cmd_phase ? EW'(CMD_LIMIT) : mag;
    len    = REM_W'((eff < lim) ? eff : lim);
  end
endmodule

// File: rtl/xfer_remain.sv
// Remaining-length tracker with a valid/ready beat input.
module xfer_remain #(
  parameter int REM_W = 17,
  parameter int MV_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [REM_W-1:0] start_len,
  input  logic             mv_valid,
  input  logic [MV_W-1:0]  mv_bytes,
  output logic             mv_ready,
  output logic [REM_W-1:0] rem,
  output logic             busy,
  output logic [REM_W-1:0] moved,
  output logic             fin,
  output logic             done
);
  logic             beat;
  logic [REM_W-1:0] bytes_x;

  always_comb begin
    mv_ready = busy && !start;
    beat     = mv_valid && mv_ready;
    bytes_x  = REM_W'(mv_bytes);
    moved    = beat ? ((bytes_x < rem) ? bytes_x : rem) : '0;
    fin      = (start && (start_len == '0)) || (beat && (moved == rem));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= fin;
      if (start) begin
        rem  <= start_len;
        busy <= (start_len != '0);
      end else if (beat) begin
        rem <= rem - moved;
        if (moved == rem) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/xfer_len_counter.sv
module xfer_len_counter #(
  parameter int CNT_W     = 16,
  parameter int PEND_W    = 18,
  parameter int MV_W      = 8,
  parameter int CMD_LIMIT = 32,
  localparam int NBYTES   = CNT_W / 8,
  localparam int SEL_W    = (NBYTES > 1) ? $clog2(NBYTES) : 1,
  localparam int REM_W    = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_wr_en,
  input  logic [SEL_W-1:0]  cnt_wr_sel,
  input  logic [7:0]        cnt_wr_data,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_code,
  input  logic [PEND_W-1:0] pend_len,
  input  logic              cmd_phase,
  input  logic              mv_valid,
  input  logic [MV_W-1:0]   mv_bytes,
  output logic              mv_ready,
  input  logic              irq_ack,
  output logic [PEND_W-1:0] pend_out,
  output logic [CNT_W-1:0]  cnt_live,
  output logic [REM_W-1:0]  rem_len,
  output logic              busy,
  output logic              tc,
  output logic              irq,
  output logic [7:0]        intr_code,
  output logic              done
);
  import xfer_cnt_pkg::*;

  logic             reload, start, fin;
  logic [CNT_W-1:0] stage;
  logic [REM_W-1:0] start_len, moved;

  assign reload = cmd_valid && cmd_code[7];
  assign start  = reload && (cmd_code[6:0] == OP_XFER_INFO);

  xfer_cnt_regs #(.CNT_W(CNT_W), .NBYTES(NBYTES), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cnt_wr_en), .wr_sel(cnt_wr_sel),
    .wr_data(cnt_wr_data), .reload(reload), .clear(fin),
    .stage(stage), .live(cnt_live)
  );

  xfer_len_calc #(.CNT_W(CNT_W), .PEND_W(PEND_W), .CMD_LIMIT(CMD_LIMIT)) u_calc (
    .count(stage), .cmd_phase(cmd_phase), .pend(pend_len), .len(start_len)
  );

  xfer_remain #(.REM_W(REM_W), .MV_W(MV_W)) u_rem (
    .clk(clk), .rst_n(rst_n), .start(start), .start_len(start_len),
    .mv_valid(mv_valid), .mv_bytes(mv_bytes), .mv_ready(mv_ready),
    .rem(rem_len), .busy(busy), .moved(moved), .fin(fin), .done(done)
  );

  // Pending phase length moves toward zero from either side.
  logic [PEND_W-1:0] moved_x;
  always_comb begin
    moved_x  = PEND_W'(moved);
    pend_out = pend_len[PEND_W-1] ? (pend_len + moved_x) : (pend_len - moved_x);
  end

  // Completion has priority over every clearing source.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tc        <= 1'b0;
      irq       <= 1'b0;
      intr_code <= '0;
    end else if (fin) begin
      tc        <= 1'b1;
      irq       <= 1'b1;
      intr_code <= INTR_BUS_SERVICE;
    end else begin
      if (start || cnt_wr_en || irq_ack) tc <= 1'b0;
      if (irq_ack) begin
        irq       <= 1'b0;
        intr_code <= '0;
      end
    end
  end
endmodule

// File: rtl/xfer_len_counter_chk.sv
module xfer_len_counter_chk #(
  parameter int CNT_W  = 16,
  parameter int PEND_W = 18,
  parameter int MV_W   = 8,
  localparam int REM_W = CNT_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cnt_wr_en,
  input logic              cmd_valid,
  input logic [PEND_W-1:0] pend_len,
  input logic              mv_valid,
  input logic [MV_W-1:0]   mv_bytes,
  input logic              mv_ready,
  input logic              irq_ack,
  input logic [PEND_W-1:0] pend_out,
  input logic [CNT_W-1:0]  cnt_live,
  input logic [REM_W-1:0]  rem_len,
  input logic              busy,
  input logic              tc,
  input logic              irq,
  input logic [7:0]        intr_code,
  input logic              done
);
  logic last_beat;
  assign last_beat = mv_valid && mv_ready && (REM_W'(mv_bytes) >= rem_len);

  a_r3_wr_clears_tc: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr_en && !last_beat && !cmd_valid) |=> !tc);

  a_r2_live_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid && !busy) |=> $stable(cnt_live));

  a_r7_ready_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mv_ready |-> busy);

  a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_valid && mv_ready && !cmd_valid) |=> (rem_len <= $past(rem_len)));

  a_r8_dir_out: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_valid && mv_ready && !pend_len[PEND_W-1]) |-> ($signed(pend_out) <= $signed(pend_len)));

  a_r8_dir_in: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_valid && mv_ready && pend_len[PEND_W-1]) |-> ($signed(pend_out) >= $signed(pend_len)));

  a_r9_done_flags: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (tc && irq && intr_code == 8'h10 && cnt_live == '0 && rem_len == '0 && !busy));

  a_r11_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !last_beat && !cmd_valid) |=> (!irq && intr_code == 8'h00));
endmodule

bind xfer_len_counter xfer_len_counter_chk #(.CNT_W(CNT_W), .PEND_W(PEND_W), .MV_W(MV_W)) u_chk (.*);

// File: tb/xfer_len_counter_tb.sv
module xfer_len_counter_tb;
  localparam int CNT_W = 16, PEND_W = 18, MV_W = 8, REM_W = 17;

  logic              clk = 0, rst_n = 0;
  logic              cnt_wr_en = 0, cnt_wr_sel = 0;
  logic [7:0]        cnt_wr_data = 0;
  logic              cmd_valid = 0;
  logic [7:0]        cmd_code = 0;
  logic [PEND_W-1:0] pend_len = 0;
  logic              cmd_phase = 0, mv_valid = 0, irq_ack = 0;
  logic [MV_W-1:0]   mv_bytes = 0;
  logic              mv_ready, busy, tc, irq, done;
  logic [PEND_W-1:0] pend_out;
  logic [CNT_W-1:0]  cnt_live;
  logic [REM_W-1:0]  rem_len;
  logic [7:0]        intr_code;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  xfer_len_counter u_dut (.*);

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint exp_len(int cnt, bit ph, int pend);
    longint eff = (cnt == 0) ? 65536 : cnt;
    longint mag = (pend < 0) ? -pend : pend;
    longint lim = ph ? 32 : mag;
    return (eff < lim) ? eff : lim;
  endfunction

  function automatic longint sx(logic [PEND_W-1:0] v);
    return longint'($signed(v));
  endfunction

  task automatic idle();
    cnt_wr_en = 0; cmd_valid = 0; mv_valid = 0; irq_ack = 0;
  endtask

  task automatic next();
    @(negedge clk);
    idle();
  endtask

  task automatic load_count(int v);
    cnt_wr_en = 1; cnt_wr_sel = 0; cnt_wr_data = v[7:0];
    next();
    cnt_wr_en = 1; cnt_wr_sel = 1; cnt_wr_data = v[15:8];
    next();
  endtask

  task automatic command(logic [7:0] code, bit ph, int pend);
    cmd_valid = 1; cmd_code = code; cmd_phase = ph; pend_len = PEND_W'(pend);
    next();
  endtask

  task automatic run_random(int n);
    for (int t = 0; t < n; t++) begin
      int cnt = int'($urandom_range(0, 65535));
      int pend = int'($urandom_range(0, 140000)) - 70000;
      bit ph = ($urandom_range(0, 3) == 0);
      longint er;
      if (t % 5 == 0) cnt = 0;
      load_count(cnt);
      command(8'h90, ph, pend);
      er = exp_len(cnt, ph, pend);
      chk("R5 random start length", rem_len, er);
      while (er > 0) begin
        int b = int'($urandom_range(1, 255));
        bit v = ($urandom_range(0, 3) != 0);
        longint m = v ? ((b < er) ? b : er) : 0;
        mv_valid = v; mv_bytes = MV_W'(b);
        #1;
        chk("R8 random pend_out", sx(pend_out), (pend < 0) ? pend + m : pend - m);
        next();
        er -= m;
        chk("R7 random remaining", rem_len, er);
      end
      chk("R9 random done", done, 1);
      chk("R9 random code", intr_code, 8'h10);
      irq_ack = 1;
      next();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    next();
    // R1 reset state
    chk("R1 cnt_live", cnt_live, 0);
    chk("R1 rem_len", rem_len, 0);
    chk("R1 busy", busy, 0);
    chk("R1 tc", tc, 0);
    chk("R1 irq", irq, 0);
    chk("R1 intr_code", intr_code, 0);
    chk("R1 done", done, 0);
    chk("R7 ready low when idle", mv_ready, 0);

    // R2 staging vs live
    load_count(16'h1234);
    chk("R2 live unchanged by write", cnt_live, 0);
    command(8'h00, 0, 0);
    chk("R2 no-DMA command keeps live", cnt_live, 0);
    command(8'h80, 0, 0);
    chk("R2 DMA command reloads live", cnt_live, 16'h1234);

    // R4/R5/R6/R7/R8/R9 directed transfer toward initiator
    load_count(5);
    command(8'h90, 0, 100);
    chk("R5 clamp to count", rem_len, 5);
    chk("R6 busy after start", busy, 1);
    chk("R6 tc cleared by start", tc, 0);
    mv_valid = 1; mv_bytes = 3;
    #1;
    chk("R7 ready while busy", mv_ready, 1);
    chk("R8 from device subtracts", sx(pend_out), 97);
    next();
    chk("R7 remaining after beat", rem_len, 2);
    mv_valid = 1; mv_bytes = 10;
    #1;
    chk("R8 moved clipped to remaining", sx(pend_out), 98);
    next();
    chk("R9 done pulse", done, 1);
    chk("R7 no underflow", rem_len, 0);
    chk("R9 tc set", tc, 1);
    chk("R9 irq set", irq, 1);
    chk("R9 intr code", intr_code, 8'h10);
    chk("R9 live count zeroed", cnt_live, 0);
    chk("R9 busy dropped", busy, 0);
    next();
    chk("R9 done one cycle", done, 0);

    // R3 write clears tc, R11 ack
    cnt_wr_en = 1; cnt_wr_sel = 0; cnt_wr_data = 8'h07;
    next();
    chk("R3 write clears tc", tc, 0);
    chk("R3 irq kept", irq, 1);
    irq_ack = 1;
    next();
    chk("R11 ack clears irq", irq, 0);
    chk("R11 ack clears code", intr_code, 0);

    // R4 zero count, R8 toward device, R6 restart
    load_count(0);
    command(8'h90, 0, -100000);
    chk("R4 zero count is 65536", rem_len, 65536);
    mv_valid = 1; mv_bytes = 200;
    #1;
    chk("R8 toward device adds", sx(pend_out), -99800);
    next();
    chk("R7 large remaining", rem_len, 65336);
    load_count(100);
    command(8'h90, 1, 5000);
    chk("R5 command phase limit 32", rem_len, 32);
    chk("R6 restart replaces remaining", busy, 1);
    load_count(10);
    command(8'h90, 1, 5000);
    chk("R5 command phase below limit", rem_len, 10);

    // R10 completion collides with write and ack
    mv_valid = 1; mv_bytes = 6;
    next();
    mv_valid = 1; mv_bytes = 4; cnt_wr_en = 1; cnt_wr_data = 8'h55; irq_ack = 1;
    next();
    chk("R10 tc wins over write", tc, 1);
    chk("R10 irq wins over ack", irq, 1);
    chk("R10 code posted", intr_code, 8'h10);
    irq_ack = 1;
    next();

    // R12 zero-length start
    load_count(40);
    command(8'h90, 0, 0);
    chk("R12 done at once", done, 1);
    chk("R12 tc", tc, 1);
    chk("R12 not busy", busy, 0);
    irq_ack = 1;
    next();

    run_random(40);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule